// File: doc/BRIEF.md
# Byte-masked single-port RAM with address hold

A synchronous single-port RAM of 1024 words by 36 bits, split into four 9-bit byte lanes. Each lane has its own active-high write mask bit, so one write may update any subset of lanes while the rest keep their contents. Every operation happens on a rising clock edge and only while the port clock enable is high. Reads return data through an output register one edge after the request.

The address is held in a register whose input comes from a feedback multiplexer. While the stall input is high, that register keeps its old value and the access on that edge uses the held address. A write also refreshes the output register. Masked-off lanes show the old stored contents there. Written lanes show either the new or the old contents, chosen by the `RDW_MODE` parameter.

The asynchronous reset clears only the address register and the output register. The storage array is not cleared.

Top module: `byte_ram_port`

## Requirements
- R1: While rst_ni is low, rdata_o is 0 and the address register is 0. A stalled read issued right after reset returns word 0.
- R2: A write (clk_en_i=1, we_i=1) stores wdata_i lane l into the word at the effective address for every l with byte_en_i[l]=1. Lane l occupies bits [9l+8:9l].
- R3: A lane whose byte_en_i bit is 0 keeps its stored value across a write. Any combination of enables is accepted, including all zero.
- R4: On a write edge, each lane whose enable is 0 loads the old stored lane of the addressed word into rdata_o. The result is visible after that edge.
- R5: On a write edge, each lane whose enable is 1 loads the written data into rdata_o when RDW_MODE=RDW_NEW (default), or the old stored data when RDW_MODE=RDW_OLD.
- R6: A read (clk_en_i=1, re_i=1, we_i=0) loads the word at the effective address into rdata_o. It is visible one edge later.
- R7: The effective address is addr_i when stall_i=0, and it is loaded into the address register. When stall_i=1 the previously registered address is used and the register keeps its value.
- R8: With clk_en_i=0 an edge does nothing: no write, no change of rdata_o, no change of the address register.
- R9: With re_i=0 and we_i=0, rdata_o holds its last value.
- R10: re_i and we_i act independently. Writing with re_i=0 still refreshes rdata_o as in R4/R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low asynchronous clear of address and output registers |
| clk_en_i | input | 1 | Port clock enable |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| stall_i | input | 1 | Hold the registered address |
| addr_i | input | 10 | Word address |
| byte_en_i | input | 4 | Per-lane write mask, bit l for lane l |
| wdata_i | input | 36 | Write data |
| rdata_o | output | 36 | Registered read data |

## Verification
Every result lands in rdata_o exactly one enabled edge after its request. This covers plain reads, the refreshed output on a write, and a stalled access that uses the held address. The bench drives inputs on the falling edge, lets one rising edge pass and compares on the next falling edge, so each comparison covers one edge's effect. An edge with clk_en_i low is checked the same way: the output must be unchanged after it, and a later read must show that no write took place. The asynchronous clear is checked between edges, with no clock edge involved.

// File: rtl/byte_ram_pkg.sv
package byte_ram_pkg;
  typedef enum logic {RDW_OLD = 1'b0, RDW_NEW = 1'b1} rdw_mode_e;
endpackage

// File: rtl/byte_ram_addr_reg.sv
module byte_ram_addr_reg #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              stall_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_eff_o,
  output logic [ADDR_W-1:0] addr_q_o
);
  logic [ADDR_W-1:0] addr_q;

  // feedback mux: stall recirculates the held address
  always_comb addr_eff_o = stall_i ? addr_q : addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (clk_en_i) addr_q <= addr_eff_o;
  end

  assign addr_q_o = addr_q;
endmodule

// File: rtl/byte_ram_lane.sv
module byte_ram_lane
  import byte_ram_pkg::*;
#(
  parameter int        ADDR_W   = 10,
  parameter int        LANE_W   = 9,
  parameter rdw_mode_e RDW_MODE = RDW_NEW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              lane_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] old_data;
  logic [LANE_W-1:0] rd_next;
  logic              lane_wr;
  logic [LANE_W-1:0] rd_q;

  assign lane_wr  = we_i && lane_en_i;
  assign old_data = mem[addr_i];

  generate
    if (RDW_MODE == RDW_NEW) begin : g_new
      assign rd_next = lane_wr ? wdata_i : old_data;
    end else begin : g_old
      assign rd_next = old_data;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (clk_en_i && lane_wr) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rd_q <= '0;
    else if (clk_en_i && (re_i || we_i)) rd_q <= rd_next;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/byte_ram_port.sv
module byte_ram_port
  import byte_ram_pkg::*;
#(
  parameter int        ADDR_W   = 10,
  parameter int        LANES    = 4,
  parameter int        LANE_W   = 9,
  parameter rdw_mode_e RDW_MODE = RDW_NEW,
  localparam int       DATA_W   = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              stall_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  byte_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_eff;
  logic [ADDR_W-1:0] addr_q;

  byte_ram_addr_reg #(.ADDR_W(ADDR_W)) i_addr_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_en_i  (clk_en_i),
    .stall_i   (stall_i),
    .addr_i    (addr_i),
    .addr_eff_o(addr_eff),
    .addr_q_o  (addr_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    byte_ram_lane #(
      .ADDR_W  (ADDR_W),
      .LANE_W  (LANE_W),
      .RDW_MODE(RDW_MODE)
    ) i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clk_en_i (clk_en_i),
      .we_i     (we_i),
      .re_i     (re_i),
      .lane_en_i(byte_en_i[l]),
      .addr_i   (addr_eff),
      .wdata_i  (wdata_i[l*LANE_W +: LANE_W]),
      .rdata_o  (rdata_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/byte_ram_port_chk.sv
module byte_ram_port_chk
  import byte_ram_pkg::*;
#(
  parameter int        ADDR_W   = 10,
  parameter int        LANES    = 4,
  parameter int        LANE_W   = 9,
  parameter rdw_mode_e RDW_MODE = RDW_NEW,
  localparam int       DATA_W   = LANES * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_i,
  input logic              we_i,
  input logic              re_i,
  input logic              stall_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [LANES-1:0]  byte_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [ADDR_W-1:0] addr_q
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (rdata_o == '0 && addr_q == '0);
    end
  end

  assert_addr_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i && !stall_i |=> addr_q == $past(addr_i));

  assert_addr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_i && stall_i |=> $stable(addr_q));

  assert_gated_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> $stable(rdata_o) && $stable(addr_q));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i && !we_i |=> $stable(rdata_o));

  if (RDW_MODE == RDW_NEW) begin : g_new_chk
    for (genvar l = 0; l < LANES; l++) begin : g_l
      assert_new_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clk_en_i && we_i && byte_en_i[l]
        |=> rdata_o[l*LANE_W +: LANE_W] == $past(wdata_i[l*LANE_W +: LANE_W]));
    end
  end
endmodule

bind byte_ram_port byte_ram_port_chk #(
  .ADDR_W  (ADDR_W),
  .LANES   (LANES),
  .LANE_W  (LANE_W),
  .RDW_MODE(RDW_MODE)
) i_byte_ram_port_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clk_en_i (clk_en_i),
  .we_i     (we_i),
  .re_i     (re_i),
  .stall_i  (stall_i),
  .addr_i   (addr_i),
  .byte_en_i(byte_en_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .addr_q   (addr_q)
);

// File: tb/test_byte_ram_port.sv
module test_byte_ram_port;
  localparam int ADDR_W = 10;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct packed {
    logic              en;
    logic              we;
    logic              re;
    logic              stall;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] wd;
    logic [DATA_W-1:0] exp;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 10'd5, 4'hF, 36'h123456789, 36'h123456789}, // R2 R5 R10
    '{1'b1, 1'b1, 1'b0, 1'b0, 10'd7, 4'hF, 36'hFEDCBA987, 36'hFEDCBA987}, // R2
    '{1'b1, 1'b1, 1'b0, 1'b0, 10'd5, 4'h5, 36'h000000000, 36'h120016600}, // R4 R5
    '{1'b1, 1'b0, 1'b1, 1'b0, 10'd5, 4'h0, 36'h0,         36'h120016600}, // R3 R6
    '{1'b1, 1'b0, 1'b1, 1'b0, 10'd7, 4'h0, 36'h0,         36'hFEDCBA987}, // R6
    '{1'b1, 1'b0, 1'b1, 1'b1, 10'd5, 4'h0, 36'h0,         36'hFEDCBA987}, // R7 stall keeps 7
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd5, 4'hF, 36'h0,         36'hFEDCBA987}, // R8
    '{1'b1, 1'b0, 1'b1, 1'b0, 10'd5, 4'h0, 36'h0,         36'h120016600}, // R8 no write
    '{1'b1, 1'b0, 1'b0, 1'b0, 10'd7, 4'h0, 36'h0,         36'h120016600}, // R9
    '{1'b1, 1'b1, 1'b0, 1'b0, 10'd5, 4'h0, 36'hFFFFFFFFF, 36'h120016600}, // R3 R4 zero mask
    '{1'b1, 1'b1, 1'b1, 1'b0, 10'd5, 4'h8, 36'hFFFFFFFFF, 36'hFF8016600}, // R4 R5 lane 3
    '{1'b1, 1'b0, 1'b1, 1'b0, 10'd5, 4'h0, 36'h0,         36'hFF8016600}, // R3
    '{1'b1, 1'b1, 1'b0, 1'b1, 10'd9, 4'hF, 36'h0AAAAAAAA, 36'h0AAAAAAAA}, // R7 write at held 5
    '{1'b1, 1'b0, 1'b1, 1'b0, 10'd5, 4'h0, 36'h0,         36'h0AAAAAAAA}  // R7
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              clk_en_i = 1'b0;
  logic              we_i = 1'b0;
  logic              re_i = 1'b0;
  logic              stall_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [LANES-1:0]  byte_en_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] ref_mem [16];
  logic [ADDR_W-1:0] ref_addr;
  logic [DATA_W-1:0] ref_q;

  always #10 clk_i = ~clk_i;

  byte_ram_port i_byte_ram_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_en_i (clk_en_i),
    .we_i     (we_i),
    .re_i     (re_i),
    .stall_i  (stall_i),
    .addr_i   (addr_i),
    .byte_en_i(byte_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (rdata_o !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata_o=%h expected=%h", req, rdata_o, exp);
    end
  endtask

  task automatic drive(input logic en, we, re, st, input logic [ADDR_W-1:0] a,
                       input logic [LANES-1:0] be, input logic [DATA_W-1:0] wd);
    clk_en_i = en; we_i = we; re_i = re; stall_i = st;
    addr_i = a; byte_en_i = be; wdata_i = wd;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // reference step on addresses 0..15
  task automatic model(input logic en, we, re, st, input logic [ADDR_W-1:0] a,
                       input logic [LANES-1:0] be, input logic [DATA_W-1:0] wd);
    logic [ADDR_W-1:0] eff;
    logic [DATA_W-1:0] old, nq;
    if (!en) return;
    eff = st ? ref_addr : a;
    old = ref_mem[eff[3:0]];
    nq  = old;
    for (int l = 0; l < LANES; l++) begin
      if (we && be[l]) begin
        ref_mem[eff[3:0]][l*LANE_W +: LANE_W] = wd[l*LANE_W +: LANE_W];
        nq[l*LANE_W +: LANE_W] = wd[l*LANE_W +: LANE_W];
      end
    end
    if (re || we) ref_q = nq;
    ref_addr = eff;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: rdata_o=%h expected=completion", rdata_o);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 reset output", '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].en, VECS[i].we, VECS[i].re, VECS[i].stall,
            VECS[i].addr, VECS[i].be, VECS[i].wd);
      check($sformatf("vector %0d (R2-R10 table)", i), VECS[i].exp);
    end

    // R1: async clear between edges, then stalled read returns word 0
    drive(1, 1, 0, 0, 10'd0, 4'hF, 36'h0000001FF);
    drive(1, 0, 1, 0, 10'd3, 4'h0, 36'h0);
    #3 rst_ni = 1'b0;
    #2 check("R1 async clear", '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1, 0, 1, 1, 10'd3, 4'h0, 36'h0);
    check("R1 address cleared", 36'h0000001FF);

    // random phase against reference model
    for (int a = 0; a < 16; a++) begin
      logic [DATA_W-1:0] v;
      v = {$urandom, $urandom} & {DATA_W{1'b1}};
      ref_mem[a] = v;
      drive(1, 1, 0, 0, ADDR_W'(a), 4'hF, v);
      check("R2 R5 init write", v);
    end
    ref_addr = 10'd15;
    ref_q    = ref_mem[15];
    for (int k = 0; k < 400; k++) begin
      logic en, we, re, st;
      logic [ADDR_W-1:0] a;
      logic [LANES-1:0] be;
      logic [DATA_W-1:0] wd;
      en = ($urandom % 5) != 0;
      we = $urandom % 2;
      re = $urandom % 2;
      st = ($urandom % 4) == 0;
      a  = ADDR_W'($urandom % 16);
      be = LANES'($urandom);
      wd = {$urandom, $urandom} & {DATA_W{1'b1}};
      model(en, we, re, st, a, be, wd);
      drive(en, we, re, st, a, be, wd);
      check("R3 R4 R5 R6 R7 R8 R9 random", ref_q);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule